// File: doc/BRIEF.md
# Sleep Entry and Recovery Sequencer

This block governs a low-power sleep state for a synchronous memory. A sleep request arrives active high and asynchronous to the clock. The block synchronises it and then steps through a fixed entry window before the device counts as asleep. When the request is withdrawn, a fixed recovery window must pass before normal operation resumes. Outside the awake state the block tells the access controller that no new access may start, and it forces the data outputs to high impedance. The array is never cleared, so stored contents survive sleep.

The block also watches the select and strobe inputs from the access controller. Two cases are protocol violations: the device is still selected at the moment the request is recognised, or a strobe arrives with the device selected while the block is not awake. Either one sets a sticky error flag. The sequencer has four states, each with a fixed 2-bit code on `nap_state`: awake 0, entering 1, asleep 2, recovering 3.

Top module: `nap_ctrl`

## Requirements
- R1: After a synchronous reset, `nap_state` is 0 (awake), `access_ok` is 1, `out_hiz` is 0 and `proto_err` is 0.
- R2: The request passes through a two-flop synchroniser. A request that is high before a rising edge leaves `nap_state` at 0 for two edges, and the third edge moves it to 1 (entering).
- R3: The state stays in entering (1) for exactly ENTER_CYC (default 2) cycles while the request holds, and then moves to asleep (2).
- R4: Once the synchronised request falls while asleep, the state moves to recovering (3). It stays there for exactly EXIT_CYC (default 2) cycles and then returns to awake (0).
- R5: In every state other than awake, `access_ok` is 0 and `out_hiz` is 1. In awake, `access_ok` is 1 and `out_hiz` is 0. Both change on the same edge as `nap_state`.
- R6: If the synchronised request falls during entering, the state moves to recovering and serves the full recovery window before it reaches awake.
- R7: If the synchronised request rises again during recovering, the state moves back to entering.
- R8: `proto_err` is set on the edge where the request is recognised in awake if `dev_sel` is 1 at that edge.
- R9: Outside awake, `proto_err` is set only when `addr_stb` and `dev_sel` are both 1 at the same edge. Either one alone does not set it, and both together in awake do not set it.
- R10: `proto_err` stays set through all later states until reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| dev_sel | input | 1 | All chip enables are currently active |
| addr_stb | input | 1 | An address strobe is active this cycle |
| access_ok | output | 1 | New accesses are allowed (awake only) |
| out_hiz | output | 1 | Force the data outputs to high impedance |
| proto_err | output | 1 | Sticky protocol violation flag |
| nap_state | output | 2 | Sequencer state code (0 awake, 1 entering, 2 asleep, 3 recovering) |

## Verification
The bench counts the exact edges from request to entering. A missing or extra synchroniser stage would therefore show up as a state change one cycle early or late. It times both windows to the edge, so an off-by-one counter would shorten or stretch entry or recovery. Two sequences test the edge cases: a one-cycle request pulse, which must still pass through recovery and not jump straight to awake, and a one-cycle gap during sleep, which must re-enter entering from recovering. The error tests apply strobe alone, select alone, and both in awake, all of which must leave the flag clear. They then confirm that the flag set while asleep survives waking and clears only on reset.

// File: rtl/nap_pkg.sv
package nap_pkg;
  typedef enum logic [1:0] {
    NAP_AWAKE = 2'd0,
    NAP_ENTER = 2'd1,
    NAP_SLEEP = 2'd2,
    NAP_WAKE  = 2'd3
  } nap_state_e;
endpackage

// File: rtl/nap_sync.sv
module nap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nap_fsm.sv
module nap_fsm
  import nap_pkg::*;
#(
  parameter int ENTER_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_s,
  output nap_state_e state_q,
  output nap_state_e state_d
);
  localparam int MAXC  = (ENTER_CYC > EXIT_CYC) ? ENTER_CYC : EXIT_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] ENTER_LAST = CNT_W'(ENTER_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      NAP_AWAKE: begin
        if (req_s) begin
          state_d = NAP_ENTER;
          cnt_d   = '0;
        end
      end
      NAP_ENTER: begin
        if (!req_s) begin
          state_d = NAP_WAKE;
          cnt_d   = '0;
        end else if (cnt_q == ENTER_LAST) begin
          state_d = NAP_SLEEP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      NAP_SLEEP: begin
        if (!req_s) begin
          state_d = NAP_WAKE;
          cnt_d   = '0;
        end
      end
      NAP_WAKE: begin
        if (req_s) begin
          state_d = NAP_ENTER;
          cnt_d   = '0;
        end else if (cnt_q == EXIT_LAST) begin
          state_d = NAP_AWAKE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = NAP_AWAKE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= NAP_AWAKE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/nap_guard.sv
module nap_guard
  import nap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  nap_state_e state_q,
  input  nap_state_e state_d,
  input  logic       req_s,
  input  logic       dev_sel,
  input  logic       addr_stb,
  output logic       access_ok,
  output logic       out_hiz,
  output logic       proto_err
);
  logic awake_now;
  logic sel_at_req;
  logic stb_blocked;

  assign awake_now   = (state_q == NAP_AWAKE);
  assign sel_at_req  = awake_now && req_s && dev_sel;
  assign stb_blocked = !awake_now && dev_sel && addr_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      access_ok <= 1'b1;
      out_hiz   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      access_ok <= (state_d == NAP_AWAKE);
      out_hiz   <= (state_d != NAP_AWAKE);
      proto_err <= proto_err | sel_at_req | stb_blocked;
    end
  end
endmodule

// File: rtl/nap_ctrl.sv
module nap_ctrl
  import nap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTER_CYC   = 2,
  parameter int EXIT_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic       dev_sel,
  input  logic       addr_stb,
  output logic       access_ok,
  output logic       out_hiz,
  output logic       proto_err,
  output logic [1:0] nap_state
);
  logic       req_s;
  nap_state_e st_q, st_d;

  nap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sleep_req),
    .q   (req_s)
  );

  nap_fsm #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .req_s   (req_s),
    .state_q (st_q),
    .state_d (st_d)
  );

  nap_guard u_guard (
    .clk       (clk),
    .rst       (rst),
    .state_q   (st_q),
    .state_d   (st_d),
    .req_s     (req_s),
    .dev_sel   (dev_sel),
    .addr_stb  (addr_stb),
    .access_ok (access_ok),
    .out_hiz   (out_hiz),
    .proto_err (proto_err)
  );

  assign nap_state = st_q;
endmodule

// File: rtl/nap_ctrl_chk.sv
module nap_ctrl_chk #(
  parameter int ENTER_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       dev_sel,
  input logic       addr_stb,
  input logic       access_ok,
  input logic       out_hiz,
  input logic       proto_err,
  input logic [1:0] nap_state
);
  logic [1:0]  prev_st;
  logic [15:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_st <= 2'd0;
      run_len <= 16'd1;
    end else begin
      prev_st <= nap_state;
      run_len <= (nap_state == prev_st) ? run_len + 16'd1 : 16'd1;
    end
  end

  // R1
  p_reset_awake_r1: assert property (@(posedge clk)
    rst |=> (nap_state == 2'd0 && access_ok && !out_hiz && !proto_err));

  // R3
  p_enter_len_r3: assert property (@(posedge clk) disable iff (rst)
    (prev_st == 2'd1 && nap_state == 2'd2) |-> run_len == 16'(ENTER_CYC));

  // R4
  p_recover_len_r4: assert property (@(posedge clk) disable iff (rst)
    (prev_st == 2'd3 && nap_state == 2'd0) |-> run_len == 16'(EXIT_CYC));

  // R5
  p_block_r5: assert property (@(posedge clk) disable iff (rst)
    (nap_state != 2'd0) |-> (!access_ok && out_hiz));

  p_open_r5: assert property (@(posedge clk) disable iff (rst)
    (nap_state == 2'd0) |-> (access_ok && !out_hiz));

  // R4 and R6: awake is reached only through recovering
  p_via_recover_r6: assert property (@(posedge clk) disable iff (rst)
    (nap_state != 2'd0 && nap_state != 2'd3) |=> nap_state != 2'd0);

  // R9
  p_strobe_err_r9: assert property (@(posedge clk) disable iff (rst)
    (nap_state != 2'd0 && dev_sel && addr_stb) |=> proto_err);

  // R10
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

bind nap_ctrl nap_ctrl_chk #(.ENTER_CYC(ENTER_CYC), .EXIT_CYC(EXIT_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dev_sel   (dev_sel),
  .addr_stb  (addr_stb),
  .access_ok (access_ok),
  .out_hiz   (out_hiz),
  .proto_err (proto_err),
  .nap_state (nap_state)
);

// File: tb/nap_ctrl_tb.sv
`timescale 1ns/1ps
module nap_ctrl_tb;
  localparam time CLK_PER = 20ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_req = 1'b0;
  logic       dev_sel = 1'b0;
  logic       addr_stb = 1'b0;
  logic       access_ok, out_hiz, proto_err;
  logic [1:0] nap_state;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  nap_ctrl u_dut (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .dev_sel   (dev_sel),
    .addr_stb  (addr_stb),
    .access_ok (access_ok),
    .out_hiz   (out_hiz),
    .proto_err (proto_err),
    .nap_state (nap_state)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sleep_req = 1'b0; dev_sel = 1'b0; addr_stb = 1'b0;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic go_asleep();
    sleep_req = 1'b1;
    tick(5);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 state", nap_state, 0);
    check("R1 access_ok", access_ok, 1);
    check("R1 out_hiz", out_hiz, 0);
    check("R1 proto_err", proto_err, 0);
  endtask

  task automatic t_full_cycle();
    do_reset();
    sleep_req = 1'b1;
    tick(2);
    check("R2 still awake after two edges", nap_state, 0);
    check("R5 access open while awake", access_ok, 1);
    tick(1);
    check("R2 entering on third edge", nap_state, 1);
    check("R5 access blocked entering", access_ok, 0);
    check("R5 hiz entering", out_hiz, 1);
    tick(1);
    check("R3 entering second cycle", nap_state, 1);
    tick(1);
    check("R3 asleep", nap_state, 2);
    check("R5 hiz asleep", out_hiz, 1);
    tick(4);
    check("R3 asleep holds", nap_state, 2);
    sleep_req = 1'b0;
    tick(2);
    check("R4 asleep until release seen", nap_state, 2);
    tick(1);
    check("R4 recovering", nap_state, 3);
    check("R5 access blocked recovering", access_ok, 0);
    tick(1);
    check("R4 recovering second cycle", nap_state, 3);
    tick(1);
    check("R4 awake after recovery", nap_state, 0);
    check("R5 access reopened", access_ok, 1);
    check("R5 hiz released", out_hiz, 0);
    check("R9 no error on clean cycle", proto_err, 0);
  endtask

  task automatic t_abort();
    do_reset();
    sleep_req = 1'b1;
    tick(1);
    sleep_req = 1'b0;
    tick(2);
    check("R6 pulse reaches entering", nap_state, 1);
    tick(1);
    check("R6 abort to recovering", nap_state, 3);
    tick(1);
    check("R6 recovery second cycle", nap_state, 3);
    tick(1);
    check("R6 awake after recovery", nap_state, 0);
  endtask

  task automatic t_rearm();
    do_reset();
    go_asleep();
    check("R7 asleep before gap", nap_state, 2);
    sleep_req = 1'b0;
    tick(1);
    sleep_req = 1'b1;
    tick(2);
    check("R7 recovering on gap", nap_state, 3);
    tick(1);
    check("R7 back to entering", nap_state, 1);
    tick(1);
    check("R7 entering holds", nap_state, 1);
    tick(1);
    check("R7 asleep again", nap_state, 2);
  endtask

  task automatic t_sel_at_req();
    do_reset();
    dev_sel = 1'b1;
    sleep_req = 1'b1;
    tick(2);
    check("R8 no error before recognition", proto_err, 0);
    tick(1);
    check("R8 error at recognition", proto_err, 1);
    dev_sel = 1'b0;
  endtask

  task automatic t_strobe_rules();
    do_reset();
    dev_sel = 1'b1; addr_stb = 1'b1;
    tick(3);
    check("R9 strobe with select while awake", proto_err, 0);
    check("R9 still awake", nap_state, 0);
    dev_sel = 1'b0; addr_stb = 1'b0;
    go_asleep();
    addr_stb = 1'b1;
    tick(2);
    check("R9 strobe alone asleep", proto_err, 0);
    addr_stb = 1'b0; dev_sel = 1'b1;
    tick(2);
    check("R9 select alone asleep", proto_err, 0);
    addr_stb = 1'b1;
    tick(1);
    check("R9 strobe with select asleep", proto_err, 1);
    addr_stb = 1'b0; dev_sel = 1'b0;
    sleep_req = 1'b0;
    tick(5);
    check("R10 awake again", nap_state, 0);
    check("R10 error kept after wake", proto_err, 1);
    do_reset();
    check("R10 error cleared by reset", proto_err, 0);
  endtask

  initial begin
    t_reset();
    t_full_cycle();
    t_abort();
    t_rearm();
    t_sel_at_req();
    t_strobe_rules();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PER * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule